// File: doc/BRIEF.md
# Pipelined 12×4 Unsigned Multiplier Built from Nibble Tiles

This block multiplies a 12-bit unsigned multiplicand by a 4-bit unsigned multiplier and returns the 16-bit product. The multiplicand is cut into three nibbles. Each nibble goes to its own 4×4 multiplier tile, and all three tiles use the same multiplier nibble. A ripple of 4-bit adders then folds the three shifted partial products together. The low nibble of the lowest partial product passes straight through. Each later adder joins the upper nibble of one partial product with the lower nibble of the next, plus the carry from the adder before it.

A register rank sits behind the tiles. The adder chain is then cut into groups, and each group ends in a register rank. The group size comes from the ratio of the tile delay to the adder delay. With a 6 ns tile and a 3 ns adder, two adders share a stage. With a 4 ns adder, each adder gets its own stage. In both cases the slowest stage is no longer than one tile. A valid flag travels with the data. The block accepts a new operand pair on every clock.

Top module: `mulw_pipe12x4`

## Requirements
- R1: For every input accepted with `in_valid` high, the result carries `product` = `mcand` × `mplier`, computed as unsigned numbers and exact in 16 bits.
- R2: With the default delays (6 ns tile, 3 ns adder), a pair sampled at a rising edge shows its result on `out_valid`/`product` just after the third rising edge, counting the sampling edge as the first.
- R3: With `ADDER_DELAY_NS` = 4, each adder has its own stage and the result appears just after the fourth rising edge, counting the sampling edge as the first.
- R4: A new operand pair may be presented on every clock cycle. Results come out one per cycle, in input order, with none lost or repeated.
- R5: `out_valid` repeats the pattern of `in_valid`, delayed by the latency, including every idle gap.
- R6: Operand values presented while `in_valid` is low have no effect. While `out_valid` is low, `product` holds the last valid result.
- R7: `rst` is synchronous and active high. At the edge after it is sampled, `out_valid` and `product` are 0, and no pair accepted before or during reset ever shows up as a result.
- R8: Extreme operands give exact results: 0 × anything = 0, 4095 × 15 = 61425, and values that fill one nibble while the others are zero.
- R9: With `TILE_STYLE` = 1, each tile sums AND-gated rows instead of using a product operator. The results and timing match those of style 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `mcand`/`mplier` as a pair to multiply |
| mcand | input | 12 | Unsigned multiplicand |
| mplier | input | 4 | Unsigned multiplier |
| out_valid | output | 1 | Marks `product` as a new result |
| product | output | 16 | Unsigned product; holds while `out_valid` is low |

## Verification
With default delays, a pair taken at rising edge n has its result just after edge n+2, which is three edges in all. The variant with the 4 ns adder needs one more edge. The bench drives each slot at a falling edge and keeps a history of expected results indexed by slot. At every falling edge it compares each instance against the slot exactly its own latency back. If that slot was idle, the bench expects a low `out_valid` and the product it held last. A result that arrives one cycle early or late therefore fails both at its own slot and at the slot next to it.

// File: rtl/mulw_pkg.sv
package mulw_pkg;

   // Tile implementation choices
   localparam int unsigned TILE_PRODUCT = 0;
   localparam int unsigned TILE_ROWS    = 1;

   // Adders that fit in one stage without exceeding one tile delay
   function automatic int unsigned mulw_group(input int unsigned tile_ns,
                                              input int unsigned add_ns,
                                              input int unsigned n);
      int unsigned g;
      if (add_ns == 0) begin
         g = n;
      end else begin
         g = tile_ns / add_ns;
      end
      if (g < 1) g = 1;
      if (g > n) g = n;
      return g;
   endfunction

   function automatic int unsigned mulw_add_stages(input int unsigned n,
                                                   input int unsigned g);
      return (n + g - 1) / g;
   endfunction

   // Edges from sampling to visible result, sampling edge included
   function automatic int unsigned mulw_latency(input int unsigned tile_ns,
                                                input int unsigned add_ns,
                                                input int unsigned n);
      return 1 + mulw_add_stages(n, mulw_group(tile_ns, add_ns, n));
   endfunction

endpackage

// File: rtl/mulw_tile.sv
module mulw_tile #(
   parameter int unsigned W     = 4,
   parameter int unsigned STYLE = 0,
   localparam int unsigned PW   = 2 * W
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   output logic [PW-1:0] p
);
   if (W < 1) begin : g_bad_w
      $error("mulw_tile: W must be at least 1");
   end
   if (STYLE > 1) begin : g_bad_style
      $error("mulw_tile: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_product
      assign p = PW'(a) * PW'(b);
   end else begin : g_rows
      logic [PW-1:0] rows [W];
      for (genvar r = 0; r < W; r++) begin : g_row
         assign rows[r] = PW'(a & {W{b[r]}}) << r;
      end
      always_comb begin
         p = '0;
         for (int r = 0; r < W; r++) begin
            p = p + rows[r];
         end
      end
   end
endmodule

// File: rtl/mulw_add.sv
module mulw_add #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   if (W < 1) begin : g_bad_w
      $error("mulw_add: W must be at least 1");
   end

   logic [W:0] full;
   assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign sum  = full[W-1:0];
   assign cout = full[W];
endmodule

// File: rtl/mulw_add_stage.sv
module mulw_add_stage #(
   parameter int unsigned W     = 4,
   parameter int unsigned N     = 3,
   parameter int unsigned FIRST = 0,
   parameter int unsigned COUNT = 1,
   localparam int unsigned OW   = N * W,
   localparam int unsigned PW   = (N + 1) * W,
   localparam int unsigned GW   = COUNT * W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [OW-1:0] in_a,
   input  logic [OW-1:0] in_b,
   input  logic          in_carry,
   input  logic [PW-1:0] in_res,
   output logic          out_valid,
   output logic [OW-1:0] out_a,
   output logic [OW-1:0] out_b,
   output logic          out_carry,
   output logic [PW-1:0] out_res
);
   if (COUNT < 1) begin : g_bad_count
      $error("mulw_add_stage: COUNT must be at least 1");
   end
   if (FIRST + COUNT > N) begin : g_bad_span
      $error("mulw_add_stage: adder span runs past the chain");
   end

   logic [COUNT:0]  chain;
   logic [GW-1:0]   sums;
   logic [OW-1:0]   keep_mask;
   logic [OW-1:0]   a_nxt;
   logic [OW-1:0]   b_nxt;
   logic [PW-1:0]   res_nxt;

   assign chain[0] = in_carry;

   for (genvar j = 0; j < COUNT; j++) begin : g_adder
      mulw_add #(.W(W)) u_add (
         .a   (in_a[(FIRST + j) * W +: W]),
         .b   (in_b[(FIRST + j) * W +: W]),
         .cin (chain[j]),
         .sum (sums[j * W +: W]),
         .cout(chain[j + 1])
      );
   end

   // Consumed operand nibbles are cleared; finished sum nibbles merge
   // into result positions that are still zero.
   assign keep_mask = ~(OW'({GW{1'b1}}) << (FIRST * W));

   always_comb begin
      a_nxt   = in_a & keep_mask;
      b_nxt   = in_b & keep_mask;
      res_nxt = in_res | (PW'(sums) << ((FIRST + 1) * W));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_a     <= '0;
         out_b     <= '0;
         out_carry <= 1'b0;
         out_res   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_a     <= a_nxt;
            out_b     <= b_nxt;
            out_carry <= chain[COUNT];
            out_res   <= res_nxt;
         end
      end
   end
endmodule

// File: rtl/mulw_pipe12x4.sv
module mulw_pipe12x4
   import mulw_pkg::*;
#(
   parameter int unsigned SLICE_W        = 4,
   parameter int unsigned NUM_SLICES     = 3,
   parameter int unsigned TILE_DELAY_NS  = 6,
   parameter int unsigned ADDER_DELAY_NS = 3,
   parameter int unsigned TILE_STYLE     = TILE_PRODUCT,
   localparam int unsigned MCAND_W = SLICE_W * NUM_SLICES,
   localparam int unsigned PROD_W  = MCAND_W + SLICE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [MCAND_W-1:0] mcand,
   input  logic [SLICE_W-1:0] mplier,
   output logic               out_valid,
   output logic [PROD_W-1:0]  product
);
   localparam int unsigned GROUP   = mulw_group(TILE_DELAY_NS, ADDER_DELAY_NS, NUM_SLICES);
   localparam int unsigned STAGES  = mulw_add_stages(NUM_SLICES, GROUP);
   localparam int unsigned OPND_W  = NUM_SLICES * SLICE_W;
   localparam int unsigned PP_W    = 2 * SLICE_W;
   localparam int unsigned RESID_W = 2 * OPND_W + 1;

   if (SLICE_W < 2) begin : g_bad_slice
      $error("mulw_pipe12x4: SLICE_W must be at least 2");
   end
   if (NUM_SLICES < 1) begin : g_bad_slices
      $error("mulw_pipe12x4: NUM_SLICES must be at least 1");
   end
   if (TILE_DELAY_NS == 0 || ADDER_DELAY_NS == 0) begin : g_bad_delay
      $error("mulw_pipe12x4: delays must be nonzero");
   end
   if (TILE_STYLE > TILE_ROWS) begin : g_bad_style
      $error("mulw_pipe12x4: unknown TILE_STYLE");
   end

   // ---------------- tile rank ----------------
   logic [PP_W-1:0]   pp [NUM_SLICES];
   logic [OPND_W-1:0] t_a;
   logic [OPND_W-1:0] t_b;
   logic [PROD_W-1:0] t_res;

   for (genvar i = 0; i < NUM_SLICES; i++) begin : g_tile
      mulw_tile #(.W(SLICE_W), .STYLE(TILE_STYLE)) u_tile (
         .a(mcand[i * SLICE_W +: SLICE_W]),
         .b(mplier),
         .p(pp[i])
      );
      assign t_a[i * SLICE_W +: SLICE_W] = pp[i][PP_W-1:SLICE_W];
      if (i + 1 < NUM_SLICES) begin : g_next_lo
         assign t_b[i * SLICE_W +: SLICE_W] = pp[i + 1][SLICE_W-1:0];
      end else begin : g_top_lo
         assign t_b[i * SLICE_W +: SLICE_W] = '0;
      end
   end

   assign t_res = PROD_W'(pp[0][SLICE_W-1:0]);

   // ---------------- stage boundaries ----------------
   logic              bnd_valid [STAGES + 1];
   logic [OPND_W-1:0] bnd_a     [STAGES + 1];
   logic [OPND_W-1:0] bnd_b     [STAGES + 1];
   logic              bnd_carry [STAGES + 1];
   logic [PROD_W-1:0] bnd_res   [STAGES + 1];

   always_ff @(posedge clk) begin
      if (rst) begin
         bnd_valid[0] <= 1'b0;
         bnd_a[0]     <= '0;
         bnd_b[0]     <= '0;
         bnd_res[0]   <= '0;
      end else begin
         bnd_valid[0] <= in_valid;
         if (in_valid) begin
            bnd_a[0]   <= t_a;
            bnd_b[0]   <= t_b;
            bnd_res[0] <= t_res;
         end
      end
   end

   assign bnd_carry[0] = 1'b0;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int unsigned FIRST = s * GROUP;
      localparam int unsigned COUNT = (NUM_SLICES - FIRST < GROUP) ?
                                      (NUM_SLICES - FIRST) : GROUP;
      mulw_add_stage #(
         .W    (SLICE_W),
         .N    (NUM_SLICES),
         .FIRST(FIRST),
         .COUNT(COUNT)
      ) u_stage (
         .clk      (clk),
         .rst      (rst),
         .in_valid (bnd_valid[s]),
         .in_a     (bnd_a[s]),
         .in_b     (bnd_b[s]),
         .in_carry (bnd_carry[s]),
         .in_res   (bnd_res[s]),
         .out_valid(bnd_valid[s + 1]),
         .out_a    (bnd_a[s + 1]),
         .out_b    (bnd_b[s + 1]),
         .out_carry(bnd_carry[s + 1]),
         .out_res  (bnd_res[s + 1])
      );
   end

   // Leftovers at the chain end: all zero once every adder has run
   logic [RESID_W-1:0] chain_residue;
   assign chain_residue = {bnd_a[STAGES], bnd_b[STAGES], bnd_carry[STAGES]};

   assign out_valid = bnd_valid[STAGES];
   assign product   = bnd_res[STAGES];
endmodule

// File: rtl/mulw_pipe_checker.sv
module mulw_pipe_checker
   import mulw_pkg::*;
#(
   parameter int unsigned SLICE_W        = 4,
   parameter int unsigned NUM_SLICES     = 3,
   parameter int unsigned TILE_DELAY_NS  = 6,
   parameter int unsigned ADDER_DELAY_NS = 3,
   localparam int unsigned MCAND_W = SLICE_W * NUM_SLICES,
   localparam int unsigned PROD_W  = MCAND_W + SLICE_W,
   localparam int unsigned RESID_W = 2 * MCAND_W + 1
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic [MCAND_W-1:0] mcand,
   input logic [SLICE_W-1:0] mplier,
   input logic               out_valid,
   input logic [PROD_W-1:0]  product,
   input logic [RESID_W-1:0] residue
);
   localparam int unsigned LAT = mulw_latency(TILE_DELAY_NS, ADDER_DELAY_NS, NUM_SLICES);

   logic              hv [LAT];
   logic [PROD_W-1:0] hp [LAT];
   logic              armed;

   always_ff @(posedge clk) begin
      armed <= !rst;
      if (rst) begin
         for (int i = 0; i < LAT; i++) begin
            hv[i] <= 1'b0;
            hp[i] <= '0;
         end
      end else begin
         hv[0] <= in_valid;
         hp[0] <= PROD_W'(mcand) * PROD_W'(mplier);
         for (int i = 1; i < LAT; i++) begin
            hv[i] <= hv[i - 1];
            hp[i] <= hp[i - 1];
         end
      end
   end

   // R2 R3 R5: valid emerges exactly LAT edges after it was sampled
   a_r5_valid_track: assert property (@(posedge clk) disable iff (rst)
      out_valid == hv[LAT - 1]);

   // R1 R4: each result equals the product of its own pair
   a_r1_product_exact: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> product == hp[LAT - 1]);

   // R1: every adder of the chain has run and no carry spills out
   a_r1_chain_drained: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> residue == '0);

   // R6: idle output keeps its last value
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
      (armed && !out_valid) |-> $stable(product));

   // R7: reset clears the result port on the next edge
   a_r7_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && product == '0));
endmodule

bind mulw_pipe12x4 mulw_pipe_checker #(
   .SLICE_W       (SLICE_W),
   .NUM_SLICES    (NUM_SLICES),
   .TILE_DELAY_NS (TILE_DELAY_NS),
   .ADDER_DELAY_NS(ADDER_DELAY_NS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .mcand    (mcand),
   .mplier   (mplier),
   .out_valid(out_valid),
   .product  (product),
   .residue  (chain_residue)
);

// File: tb/mulw_pipe12x4_bench.sv
module mulw_pipe12x4_bench;
   localparam int LAT_A = 3;  // R2: default delays
   localparam int LAT_B = 4;  // R3: 4 ns adder

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [11:0] mcand = '0;
   logic [3:0]  mplier = '0;
   logic        ov_a, ov_b;
   logic [15:0] p_a, p_b;

   int    checks = 0;
   int    errors = 0;
   int    slot = 0;
   bit    checking = 1'b0;
   string cur_tag = "R7";

   bit          hv [8];
   logic [15:0] hp [8];
   logic [15:0] last_a = '0;
   logic [15:0] last_b = '0;

   always #4 clk = ~clk;

   mulw_pipe12x4 u_mulw_pipe12x4 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mcand(mcand),
      .mplier(mplier), .out_valid(ov_a), .product(p_a)
   );

   mulw_pipe12x4 #(.ADDER_DELAY_NS(4), .TILE_STYLE(1)) u_mulw_pipe12x4_a4 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mcand(mcand),
      .mplier(mplier), .out_valid(ov_b), .product(p_b)
   );

   task automatic check_one(input string who, input int lat, input logic ov,
                            input logic [15:0] pv, inout logic [15:0] last);
      logic        ev;
      logic [15:0] ep;
      if (slot >= lat && hv[(slot - lat) & 7]) begin
         ev   = 1'b1;
         ep   = hp[(slot - lat) & 7];
         last = ep;
      end else begin
         ev = 1'b0;
         ep = last;
      end
      checks++;
      if (ov !== ev || pv !== ep) begin
         errors++;
         $display("FAIL %s dut %s slot %0d: valid=%b product=%0d expected valid=%b product=%0d",
                  cur_tag, who, slot, ov, pv, ev, ep);
      end
   endtask

   // One slot: compare outputs at the falling edge, then drive the next pair
   task automatic step(input bit r, input bit v, input logic [11:0] a, input logic [3:0] b);
      @(negedge clk);
      if (checking) begin
         check_one("A-R2", LAT_A, ov_a, p_a, last_a);
         check_one("B-R3-R9", LAT_B, ov_b, p_b, last_b);
      end
      if (r) begin
         for (int i = 0; i < 8; i++) hv[i] = 1'b0;
         last_a = '0;
         last_b = '0;
      end
      hv[slot & 7] = v && !r;
      hp[slot & 7] = 16'(a) * 16'(b);
      rst      = r;
      in_valid = v;
      mcand    = a;
      mplier   = b;
      slot++;
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 12'($urandom), 4'($urandom));
   endtask

   task automatic t_reset;           // R7
      cur_tag = "R7";
      step(1'b1, 1'b0, '0, '0);
      checking = 1'b1;
      step(1'b1, 1'b1, 12'hABC, 4'h7);
      step(1'b1, 1'b0, '0, '0);
      drain(6);
   endtask

   task automatic t_latency;         // R2 R3: single pulse, exact slot
      cur_tag = "R2+R3";
      step(1'b0, 1'b1, 12'h123, 4'h5);
      drain(6);
      step(1'b0, 1'b1, 12'h9E1, 4'hB);
      step(1'b0, 1'b0, '0, '0);
      step(1'b0, 1'b1, 12'h047, 4'h3);
      drain(6);
   endtask

   task automatic t_stream;          // R1 R4: back to back
      cur_tag = "R1+R4";
      for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 12'($urandom), 4'($urandom));
      drain(6);
   endtask

   task automatic t_corners;         // R8
      cur_tag = "R8";
      step(1'b0, 1'b1, 12'd0,    4'd0);
      step(1'b0, 1'b1, 12'd4095, 4'd15);
      step(1'b0, 1'b1, 12'd0,    4'd15);
      step(1'b0, 1'b1, 12'd4095, 4'd0);
      step(1'b0, 1'b1, 12'd4095, 4'd1);
      step(1'b0, 1'b1, 12'd1,    4'd15);
      step(1'b0, 1'b1, 12'hF00,  4'd15);
      step(1'b0, 1'b1, 12'h0F0,  4'd15);
      step(1'b0, 1'b1, 12'h00F,  4'd15);
      step(1'b0, 1'b1, 12'hFFF,  4'd8);
      drain(6);
   endtask

   task automatic t_bubbles;         // R5 R6: idle slots carry junk data
      cur_tag = "R5+R6";
      for (int i = 0; i < 200; i++)
         step(1'b0, ($urandom % 3) == 0, 12'($urandom), 4'($urandom));
      drain(6);
   endtask

   task automatic t_reset_flush;     // R7: in-flight pairs are dropped
      cur_tag = "R7";
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 12'($urandom), 4'($urandom));
      step(1'b1, 1'b1, 12'h555, 4'hA);
      step(1'b1, 1'b1, 12'hAAA, 4'h5);
      drain(6);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 12'($urandom), 4'($urandom));
      drain(6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog expired at slot %0d: actual running expected finished", slot);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_stream();
      t_corners();
      t_bubbles();
      t_reset_flush();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule